// File: doc/BRIEF.md
# Programmable Timer Channel with Overflow and Compare Exceptions

This block is one counting channel of a peripheral timer. A prescaler divides the clock and produces a count tick. Each tick advances a 24-bit counter. The counter reloads from a programmed start value after it passes its all-ones value. The channel raises two exception flags:

- An overflow flag, set when the counter wraps.
- A compare flag. In ordinary modes the compare flag is set when the counter reaches a programmed compare value. In the measurement modes it is set by a selected edge on an external timer input instead.

Software configures the channel through a small register port with separate write and read addresses. Each flag is cleared either by writing a one to its bit or by an acknowledge strobe from an interrupt controller. Each flag drives its own masked request line. A combined priority output presents overflow ahead of compare.

Software normally writes the start, prescale and compare values first and sets the run bit last. Setting the run bit loads the counter and the prescaler.

Register map (word addresses):

| Address | Register | Access |
|---|---|---|
| 0 | Control/status | read/write |
| 1 | Start value | read/write |
| 2 | Prescale value | read/write |
| 3 | Compare value | read/write |
| 4 | Live counter | read-only |

Control/status bits:

| Bit(s) | Meaning | Write behaviour |
|---|---|---|
| 0 | Run | read/write |
| 1 | Overflow request enable | read/write |
| 2 | Compare request enable | read/write |
| 5:3 | Mode | read/write |
| 8 | Overflow flag | write 1 to clear |
| 9 | Compare flag | write 1 to clear |

Mode values:

| Mode | Compare flag source |
|---|---|
| 4 | Rising edge of the timer input |
| 5 | Falling edge of the timer input |
| 6 | Either edge of the timer input |
| Any other value | Counter match |

Top module: `tmr_channel`

## Requirements
- R1: After reset, every register reads zero: the control/status word, the start value, the prescale value, the compare value and the live counter. All four request outputs are low.
- R2: A control write that sets the run bit (bit 0) while the channel is stopped loads the counter from the start value and the prescaler from the prescale value P, in that same edge. While running, the counter advances once every P+1 clocks. While the run bit is clear, the counter holds its value.
- R3: On a tick where the counter holds all ones, the counter reloads from the start value and the overflow flag (status bit 8) is set at that edge.
- R4: The overflow request output equals the overflow flag ANDed with its enable (bit 1). The compare request output equals the compare flag ANDed with its enable (bit 2).
- R5: Writing a one to bit 8 or bit 9 of the control/status word clears that flag, and writing a zero there leaves it unchanged. A one-cycle pulse on an acknowledge input clears the matching flag.
- R6: When a flag's set event and a clear fall in the same cycle, the flag ends up set.
- R7: In modes other than 4, 5 and 6, the compare flag (bit 9) is set at the tick where the counter steps onto the compare value.
- R8: In mode 4, a rising edge of the timer input sets the compare flag. In mode 5, a falling edge sets it. In mode 6, either edge sets it. The flag is set on the third clock edge after the input changes. Counter matches and edges of the other polarity leave the flag clear.
- R9: The pending output is high when either request output is high. The source output is high only when the compare request is the only active request, so overflow is presented first.
- R10: A control write that keeps the run bit set while the channel is already running does not reload the counter or the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 24 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 24 | Read data for rdAddr, combinational |
| tioIn | input | 1 | External timer input, asynchronous |
| ackOvf | input | 1 | Overflow service acknowledge |
| ackCmp | input | 1 | Compare service acknowledge |
| irqOvf | output | 1 | Masked overflow request |
| irqCmp | output | 1 | Masked compare request |
| irqPend | output | 1 | Any request pending |
| irqSrcCmp | output | 1 | Pending request is compare (0 means overflow) |

## Verification
The live counter is readable, so a wrong prescaler or counter load shows up as a wrong count within a few ticks of enabling the channel. A flag that was set too early or too late appears on the status bits and request lines one edge away from the cycle the bench predicts. A lost set, or a clear that wins over a set, shows up as a missing request on the cycle right after the coinciding acknowledge. A wrong edge polarity or sync depth in the measurement modes is exposed by sampling the compare flag two and three edges after the input changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic start;
    logic run;
  } tmrStrobe_t;

  typedef struct packed {
    logic ovfEvt;
    logic cntMatch;
    logic tioRise;
    logic tioFall;
  } tmrEvent_t;

  localparam logic [2:0] MODE_CAP_RISE = 3'd4;
  localparam logic [2:0] MODE_CAP_FALL = 3'd5;
  localparam logic [2:0] MODE_CAP_BOTH = 3'd6;

  function automatic logic isMeasure(input logic [2:0] m);
    return (m == MODE_CAP_RISE) || (m == MODE_CAP_FALL) || (m == MODE_CAP_BOTH);
  endfunction
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [PRE_W-1:0] preLoad,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             tioIn,
  output logic [CNT_W-1:0] cnt,
  output tmrEvent_t        evt
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cntNext;
  logic             tick;
  logic             atMax;
  logic             tioS1, tioS2, tioPrev;

  assign tick    = strb.run && !strb.start && (preCnt == '0);
  assign atMax   = (cnt == CntMax);
  assign cntNext = cnt + CNT_W'(1);

  always_comb begin
    evt.ovfEvt   = tick && atMax;
    evt.cntMatch = tick && !atMax && (cntNext == cmpVal);
    evt.tioRise  = tioS2 && !tioPrev;
    evt.tioFall  = !tioS2 && tioPrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      preCnt <= '0;
    end else if (strb.start) begin
      cnt    <= loadVal;
      preCnt <= preLoad;
    end else if (strb.run) begin
      if (preCnt == '0) begin
        preCnt <= preLoad;
        cnt    <= atMax ? loadVal : cntNext;
      end else begin
        preCnt <= preCnt - PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tioS1   <= 1'b0;
      tioS2   <= 1'b0;
      tioPrev <= 1'b0;
    end else begin
      tioS1   <= tioIn;
      tioS2   <= tioS1;
      tioPrev <= tioS2;
    end
  end

  // R2: starting loads the counter from the start value
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> cnt == $past(loadVal));

  // R2: a stopped counter holds
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.start) |=> $stable(cnt));

  // R3: wrap reloads from the start value
  a_r3_wrap_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.start && preCnt == '0 && cnt == CntMax) |=> cnt == $past(loadVal));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              ackOvf,
  input  logic              ackCmp,
  input  logic [CNT_W-1:0]  cnt,
  input  tmrEvent_t         evt,
  output tmrStrobe_t        strb,
  output logic [CNT_W-1:0]  loadReg,
  output logic [PRE_W-1:0]  preReg,
  output logic [CNT_W-1:0]  cmpReg,
  output logic              irqOvf,
  output logic              irqCmp,
  output logic              irqPend,
  output logic              irqSrcCmp
);
  localparam int BIT_RUN = 0;
  localparam int BIT_OIE = 1;
  localparam int BIT_CIE = 2;
  localparam int BIT_MODE = 3;
  localparam int BIT_OVF = 8;
  localparam int BIT_CMP = 9;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);

  logic       runEn, ovfIe, cmpIe, ovfFlag, cmpFlag;
  logic [2:0] mode;
  logic       ctrlWr, ovfSet, cmpSet, ovfClr, cmpClr, edgeHit;

  assign ctrlWr     = wrEn && (wrAddr == A_CTRL);
  assign strb.start = ctrlWr && wrData[BIT_RUN] && !runEn;
  assign strb.run   = runEn;

  always_comb begin
    unique case (mode)
      MODE_CAP_RISE: edgeHit = evt.tioRise;
      MODE_CAP_FALL: edgeHit = evt.tioFall;
      MODE_CAP_BOTH: edgeHit = evt.tioRise || evt.tioFall;
      default:       edgeHit = 1'b0;
    endcase
  end

  assign ovfSet = evt.ovfEvt;
  assign cmpSet = isMeasure(mode) ? (edgeHit && runEn) : evt.cntMatch;
  assign ovfClr = (ctrlWr && wrData[BIT_OVF]) || ackOvf;
  assign cmpClr = (ctrlWr && wrData[BIT_CMP]) || ackCmp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      ovfIe   <= 1'b0;
      cmpIe   <= 1'b0;
      mode    <= '0;
      loadReg <= '0;
      preReg  <= '0;
      cmpReg  <= '0;
    end else if (wrEn) begin
      unique case (wrAddr)
        A_CTRL: begin
          runEn <= wrData[BIT_RUN];
          ovfIe <= wrData[BIT_OIE];
          cmpIe <= wrData[BIT_CIE];
          mode  <= wrData[BIT_MODE +: 3];
        end
        A_LOAD:  loadReg <= wrData;
        A_PRE:   preReg  <= wrData[PRE_W-1:0];
        A_CMP:   cmpReg  <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      if (ovfSet)      ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
      if (cmpSet)      cmpFlag <= 1'b1;
      else if (cmpClr) cmpFlag <= 1'b0;
    end
  end

  assign irqOvf    = ovfFlag && ovfIe;
  assign irqCmp    = cmpFlag && cmpIe;
  assign irqPend   = irqOvf || irqCmp;
  assign irqSrcCmp = irqCmp && !irqOvf;

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      A_CTRL: begin
        rdData[BIT_RUN]        = runEn;
        rdData[BIT_OIE]        = ovfIe;
        rdData[BIT_CIE]        = cmpIe;
        rdData[BIT_MODE +: 3]  = mode;
        rdData[BIT_OVF]        = ovfFlag;
        rdData[BIT_CMP]        = cmpFlag;
      end
      A_LOAD:  rdData = loadReg;
      A_PRE:   rdData = CNT_W'(preReg);
      A_CMP:   rdData = cmpReg;
      A_CNT:   rdData = cnt;
      default: rdData = '0;
    endcase
  end

  // R6: a set event always leaves the flag set
  a_r6_ovf_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    ovfSet |=> ovfFlag);
  a_r6_cmp_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    cmpSet |=> cmpFlag);

  // R5: acknowledge without a set clears the flag
  a_r5_ack_clears_cmp: assert property (@(posedge clk) disable iff (!rstN)
    (ackCmp && !cmpSet) |=> !cmpFlag);
  a_r5_ack_clears_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (ackOvf && !ovfSet) |=> !ovfFlag);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              tioIn,
  input  logic              ackOvf,
  input  logic              ackCmp,
  output logic              irqOvf,
  output logic              irqCmp,
  output logic              irqPend,
  output logic              irqSrcCmp
);
  tmrStrobe_t       strb;
  tmrEvent_t        evt;
  logic [CNT_W-1:0] cnt, loadReg, cmpReg;
  logic [PRE_W-1:0] preReg;

  tmr_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ackOvf(ackOvf), .ackCmp(ackCmp),
    .cnt(cnt), .evt(evt), .strb(strb), .loadReg(loadReg), .preReg(preReg),
    .cmpReg(cmpReg), .irqOvf(irqOvf), .irqCmp(irqCmp), .irqPend(irqPend),
    .irqSrcCmp(irqSrcCmp)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadReg), .preLoad(preReg),
    .cmpVal(cmpReg), .tioIn(tioIn), .cnt(cnt), .evt(evt)
  );
endmodule

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [23:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [23:0] rdData;
  logic        tioIn = 1'b0;
  logic        ackOvf = 1'b0;
  logic        ackCmp = 1'b0;
  logic        irqOvf, irqCmp, irqPend, irqSrcCmp;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  string       reqQ[$];
  logic [31:0] expQ[$];

  tmr_channel dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tioIn(tioIn), .ackOvf(ackOvf),
    .ackCmp(ackCmp), .irqOvf(irqOvf), .irqCmp(irqCmp), .irqPend(irqPend),
    .irqSrcCmp(irqSrcCmp)
  );

  always #10 clk = ~clk;

  // driver side: queue what the requirement predicts
  task automatic pushExp(input string r, input logic [31:0] e);
    reqQ.push_back(r);
    expQ.push_back(e);
  endtask

  // monitor side: pop the prediction and compare with the sampled port value
  task automatic observe(input logic [31:0] act);
    string r;
    logic [31:0] e;
    r = reqQ.pop_front();
    e = expQ.pop_front();
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, e);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [23:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [23:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic chkReg(input string r, input logic [2:0] a, input logic [23:0] e);
    logic [23:0] v;
    pushExp(r, 32'(e));
    regRead(a, v);
    observe(32'(v));
  endtask

  task automatic chkBit(input string r, input int bitPos, input logic e);
    logic [23:0] v;
    pushExp(r, 32'(e));
    regRead(3'd0, v);
    observe(32'(v[bitPos]));
  endtask

  task automatic chkPin(input string r, input logic act, input logic e);
    pushExp(r, 32'(e));
    observe(32'(act));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chkReg("R1 ctrl", 3'd0, 24'h0);
    chkReg("R1 load", 3'd1, 24'h0);
    chkReg("R1 count", 3'd4, 24'h0);
    chkPin("R1 pend", irqPend, 1'b0);
    chkPin("R1 irqOvf", irqOvf, 1'b0);

    // R2 start load and prescaled counting
    regWrite(3'd1, 24'd10);
    regWrite(3'd2, 24'd2);
    regWrite(3'd0, 24'h000001);
    chkReg("R2 start load", 3'd4, 24'd10);
    cyc(9);
    chkReg("R2 prescaled count", 3'd4, 24'd13);
    regWrite(3'd0, 24'h000000);
    cyc(6);
    chkReg("R2 stopped hold", 3'd4, 24'd13);

    // R3 overflow
    regWrite(3'd1, 24'hFFFFFE);
    regWrite(3'd2, 24'd0);
    regWrite(3'd3, 24'h000005);
    regWrite(3'd0, 24'h000001);
    cyc(1);
    chkBit("R3 flag before wrap", 8, 1'b0);
    cyc(1);
    chkBit("R3 flag at wrap", 8, 1'b1);
    chkReg("R3 reload", 3'd4, 24'hFFFFFE);
    chkPin("R4 masked ovf", irqOvf, 1'b0);
    // R10 enable request while running, no restart
    regWrite(3'd0, 24'h000003);
    chkReg("R10 no restart", 3'd4, 24'hFFFFFF);
    chkPin("R4 enabled ovf", irqOvf, 1'b1);
    // R6 ack together with a wrap
    ackOvf = 1'b1;
    cyc(1);
    chkBit("R6 set wins", 8, 1'b1);
    cyc(1);
    ackOvf = 1'b0;
    chkBit("R5 ack clears ovf", 8, 1'b0);
    regWrite(3'd0, 24'h000002);
    chkBit("R3 flag from last wrap", 8, 1'b1);
    regWrite(3'd0, 24'h000002);
    chkBit("R5 write zero keeps", 8, 1'b1);
    regWrite(3'd0, 24'h000102);
    chkBit("R5 w1c ovf", 8, 1'b0);
    chkPin("R4 ovf after clear", irqOvf, 1'b0);

    // R7 compare in count mode
    regWrite(3'd1, 24'd0);
    regWrite(3'd3, 24'd5);
    regWrite(3'd0, 24'h000005);
    cyc(4);
    chkBit("R7 no match yet", 9, 1'b0);
    cyc(1);
    chkBit("R7 match", 9, 1'b1);
    chkPin("R4 cmp request", irqCmp, 1'b1);

    // R9 priority
    regWrite(3'd0, 24'h000004);
    regWrite(3'd1, 24'hFFFFFF);
    regWrite(3'd0, 24'h000007);
    cyc(1);
    chkPin("R9 pend both", irqPend, 1'b1);
    chkPin("R9 ovf first", irqSrcCmp, 1'b0);
    regWrite(3'd0, 24'h000006);
    regWrite(3'd0, 24'h000106);
    chkPin("R9 pend cmp", irqPend, 1'b1);
    chkPin("R9 cmp source", irqSrcCmp, 1'b1);
    ackCmp = 1'b1;
    cyc(1);
    ackCmp = 1'b0;
    chkBit("R5 ack clears cmp", 9, 1'b0);

    // R8 measurement modes
    regWrite(3'd1, 24'd0);
    regWrite(3'd3, 24'd2);
    regWrite(3'd0, 24'h000025);
    cyc(5);
    chkBit("R8 match ignored", 9, 1'b0);
    tioIn = 1'b1;
    cyc(2);
    chkBit("R8 rise sync delay", 9, 1'b0);
    cyc(1);
    chkBit("R8 rise mode4", 9, 1'b1);
    ackCmp = 1'b1;
    cyc(1);
    ackCmp = 1'b0;
    tioIn = 1'b0;
    cyc(5);
    chkBit("R8 fall ignored mode4", 9, 1'b0);
    regWrite(3'd0, 24'h00002D);
    tioIn = 1'b1;
    cyc(5);
    chkBit("R8 rise ignored mode5", 9, 1'b0);
    tioIn = 1'b0;
    cyc(3);
    chkBit("R8 fall mode5", 9, 1'b1);
    ackCmp = 1'b1;
    cyc(1);
    ackCmp = 1'b0;
    regWrite(3'd0, 24'h000035);
    tioIn = 1'b1;
    cyc(3);
    chkBit("R8 either mode6", 9, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule